// File: doc/BRIEF.md
# CCD Vertical Row-Transfer Clock Sequencer

This block produces the logic-level timing for moving one row of charge in a full-frame CCD from the image columns into the horizontal readout register. A one-cycle start pulse launches a fixed, ordered list of edges on three vertical phase clocks, a transfer gate and horizontal phase 1. The gap before each edge is a whole number of system clock ticks. These tick counts are worked out at elaboration time from nanosecond parameters and the clock frequency.

Two edge orderings are built in. Standard mode keeps the vertical phases partly high while the array integrates. Pinned-phase mode keeps every vertical phase low while the array integrates. Horizontal phase 1 is pulled low at the start and held there for the whole transfer, so no vertical phase ever moves while the horizontal clock is toggling. When horizontal phase 1 is released at the end, a one-cycle done pulse marks the finish of the row. Analog drivers, slew control and pixel readout lie outside this block.

Top module: `vxs_seq`

## Requirements
- R1: While idle, TG is low and H1 is high. The vertical phases show the idle levels of the mode on `mpp_i` as sampled at the previous clock edge, including during reset. Standard mode (`mpp_i`=0) gives V1=1, V2=1, V3=0. Pinned mode (`mpp_i`=1) gives V1=V2=V3=0.
- R2: A start pulse seen while idle drops H1 and raises TG on the next clock edge, with no change to the vertical phases.
- R3: In standard mode the later edges come in this order, with these gaps from the previous edge: V1 falls (2600 ns), V3 rises (2600 ns), V2 falls (2600 ns), V1 rises (5200 ns), V3 falls (1400 ns), V2 rises (1400 ns), TG falls (4600 ns), H1 rises (2600 ns).
- R4: In pinned mode the later edges come in this order, with these gaps: V2 rises (2600 ns), V3 rises (5200 ns), V2 falls (2600 ns), V1 rises (2600 ns), V3 falls (2800 ns), TG falls together with V1 falling (4600 ns), H1 rises (2600 ns). All vertical phases are low when the sequence ends.
- R5: Each gap is ceil(ns × CLK_MHZ / 1000) clock ticks. The default is CLK_MHZ=200, so 2600 ns is 520 ticks.
- R6: `done_o` is high for exactly one cycle: the cycle in which H1 returns high. It is never high at any other time.
- R7: A start pulse during a running sequence is ignored. A change on `mpp_i` during a running sequence does not alter that sequence, which keeps the mode latched when it started.
- R8: The vertical phases change only in cycles where H1 does not change. TG is high only while H1 is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start one row transfer (one-cycle pulse) |
| mpp_i | input | 1 | Mode select: 0 standard, 1 pinned-phase |
| v1_o | output | 1 | Vertical phase 1 level |
| v2_o | output | 1 | Vertical phase 2 level |
| v3_o | output | 1 | Vertical phase 3 level |
| tg_o | output | 1 | Transfer gate level |
| h1_o | output | 1 | Horizontal phase 1 level (held low during transfer) |
| done_o | output | 1 | One-cycle pulse when H1 returns high |

## Verification
The assertions watch three things on every cycle. They check that the vertical phases never move in a cycle where H1 moves, and that TG is never high while H1 is high. They also check that done comes exactly and only with a rising H1, and that a pinned-mode run ends with all vertical phases low. The order of the edges, the exact tick distance between them, and the idle levels after reset and after a mode change can only be shown by the bench scenarios. The same is true of ignoring a start pulse or a mode change during a run. The bench shows these by following every edge of full runs in both modes.

// File: rtl/vxs_pkg.sv
`timescale 1ns/1ps
// Package: shared types and helpers for the vertical row-transfer sequencer.
// Assumes one level vector carries every driven clock, ordered V1,V2,V3,TG,H1.
package vxs_pkg;

    // Levels of all driven clocks at one point in the sequence
    typedef struct packed {
        logic v1;
        logic v2;
        logic v3;
        logic tg;
        logic h1;
    } vxs_lvl_t;

    // Width of the step index (up to 16 steps)
    localparam int STEP_W = 4;

    // Idle (integration) levels for the given mode
    function automatic vxs_lvl_t vxs_idle(input logic mpp);
        return mpp ? 5'b00001 : 5'b11001;
    endfunction

    // Nanoseconds to clock ticks, rounded up
    function automatic int unsigned vxs_ns2tick(input int unsigned ns, input int unsigned mhz);
        return (ns * mhz + 999) / 1000;
    endfunction

    // Larger of two values
    function automatic int unsigned vxs_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/vxs_edge_table.sv
`timescale 1ns/1ps
// Module: edge table. For a mode and a step index, returns the clock levels
// after that step, the gap in ticks to the following step, and whether it is
// the final step. Purely combinational.
// Assumes every gap parameter is at least 1 tick and fits in CNT_W bits.
module vxs_edge_table
    import vxs_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int G_BASE  = 520,
    parameter int G_LONG  = 1040,
    parameter int G_SHORT = 280,
    parameter int G_MPP   = 560,
    parameter int G_TG    = 920
) (
    input  logic              mpp_i,
    input  logic [STEP_W-1:0] idx_i,
    output vxs_lvl_t          lvl_o,
    output logic [CNT_W-1:0]  gap_o,
    output logic              last_o
);

    int gap;

    // Look up the step entry of the selected ordering
    always_comb begin
        lvl_o  = vxs_idle(mpp_i);
        gap    = G_BASE;
        last_o = 1'b0;
        if (!mpp_i) begin
            case (idx_i)
                4'd0: begin lvl_o = 5'b11010; gap = G_BASE;  end
                4'd1: begin lvl_o = 5'b01010; gap = G_BASE;  end
                4'd2: begin lvl_o = 5'b01110; gap = G_BASE;  end
                4'd3: begin lvl_o = 5'b00110; gap = G_LONG;  end
                4'd4: begin lvl_o = 5'b10110; gap = G_SHORT; end
                4'd5: begin lvl_o = 5'b10010; gap = G_SHORT; end
                4'd6: begin lvl_o = 5'b11010; gap = G_TG;    end
                4'd7: begin lvl_o = 5'b11000; gap = G_BASE;  end
                4'd8: begin lvl_o = 5'b11001; last_o = 1'b1; end
                default: ;
            endcase
        end else begin
            case (idx_i)
                4'd0: begin lvl_o = 5'b00010; gap = G_BASE;  end
                4'd1: begin lvl_o = 5'b01010; gap = G_LONG;  end
                4'd2: begin lvl_o = 5'b01110; gap = G_BASE;  end
                4'd3: begin lvl_o = 5'b00110; gap = G_BASE;  end
                4'd4: begin lvl_o = 5'b10110; gap = G_MPP;   end
                4'd5: begin lvl_o = 5'b10010; gap = G_TG;    end
                4'd6: begin lvl_o = 5'b00000; gap = G_BASE;  end
                4'd7: begin lvl_o = 5'b00001; last_o = 1'b1; end
                default: ;
            endcase
        end
    end

    assign gap_o = CNT_W'(gap);

endmodule

// File: rtl/vxs_gap_timer.sv
`timescale 1ns/1ps
// Module: gap timer. A down-counter that loads a value and counts to zero,
// then stays there. zero_o is high whenever the count is zero.
// Assumes a load of N makes zero_o rise N cycles later.
module vxs_gap_timer #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    // Load or count down toward zero
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load_i)         cnt_q <= val_i;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/vxs_seq.sv
`timescale 1ns/1ps
// Module: vertical row-transfer sequencer (top). Steps through the edge list
// of the mode latched at start, spacing edges by the gap timer, and pulses
// done when H1 returns high.
// Assumes start_i is synchronous; mpp_i is sampled while idle, and the mode
// shown on the idle outputs is the mode that the sequence uses.
module vxs_seq
    import vxs_pkg::*;
#(
    parameter int CLK_MHZ    = 200,
    parameter int T_BASE_NS  = 2600,
    parameter int T_LONG_NS  = 5200,
    parameter int T_SHORT_NS = 1400,
    parameter int T_MPP_NS   = 2800,
    parameter int T_TG_NS    = 4600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic mpp_i,
    output logic v1_o,
    output logic v2_o,
    output logic v3_o,
    output logic tg_o,
    output logic h1_o,
    output logic done_o
);

    localparam int G_BASE  = vxs_ns2tick(T_BASE_NS,  CLK_MHZ);
    localparam int G_LONG  = vxs_ns2tick(T_LONG_NS,  CLK_MHZ);
    localparam int G_SHORT = vxs_ns2tick(T_SHORT_NS, CLK_MHZ);
    localparam int G_MPP   = vxs_ns2tick(T_MPP_NS,   CLK_MHZ);
    localparam int G_TG    = vxs_ns2tick(T_TG_NS,    CLK_MHZ);
    localparam int G_MAX   = vxs_max(vxs_max(G_BASE, G_LONG),
                                     vxs_max(vxs_max(G_SHORT, G_MPP), G_TG));
    localparam int CNT_W   = $clog2(G_MAX + 1);

    logic              busy_q;
    logic              mode_q;
    logic              done_q;
    logic [STEP_W-1:0] idx_q;
    vxs_lvl_t          lvl_q;

    vxs_lvl_t          tbl_lvl;
    logic [CNT_W-1:0]  tbl_gap;
    logic              tbl_last;
    logic              tmr_zero;
    logic              fire;
    logic              tmr_load;

    vxs_edge_table #(
        .CNT_W(CNT_W), .G_BASE(G_BASE), .G_LONG(G_LONG),
        .G_SHORT(G_SHORT), .G_MPP(G_MPP), .G_TG(G_TG)
    ) u_table (
        .mpp_i (mode_q),
        .idx_i (idx_q),
        .lvl_o (tbl_lvl),
        .gap_o (tbl_gap),
        .last_o(tbl_last)
    );

    // A step is due when running and the gap has elapsed
    assign fire     = busy_q && tmr_zero;
    assign tmr_load = (!busy_q && start_i) || (fire && !tbl_last);

    vxs_gap_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(tmr_load),
        .val_i (tbl_gap - CNT_W'(1)),
        .zero_o(tmr_zero)
    );

    // Sequence control: idle tracking, start, step advance and done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
            mode_q <= mpp_i;
            lvl_q  <= vxs_idle(mpp_i);
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start_i) begin
                    busy_q <= 1'b1;
                    lvl_q  <= tbl_lvl;
                    idx_q  <= STEP_W'(1);
                end else begin
                    mode_q <= mpp_i;
                    lvl_q  <= vxs_idle(mpp_i);
                end
            end else if (tmr_zero) begin
                lvl_q <= tbl_lvl;
                if (tbl_last) begin
                    busy_q <= 1'b0;
                    idx_q  <= '0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + STEP_W'(1);
                end
            end
        end
    end

    assign v1_o   = lvl_q.v1;
    assign v2_o   = lvl_q.v2;
    assign v3_o   = lvl_q.v3;
    assign tg_o   = lvl_q.tg;
    assign h1_o   = lvl_q.h1;
    assign done_o = done_q;

endmodule

// File: rtl/vxs_seq_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for the sequencer, attached by bind.
// Assumes it sees the top-level outputs and the latched mode.
module vxs_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic v1_i,
    input logic v2_i,
    input logic v3_i,
    input logic tg_i,
    input logic h1_i,
    input logic done_i,
    input logic mode_i
);

    AST_V_MOVES_H_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({v1_i, v2_i, v3_i}) |-> $stable(h1_i)); // R8

    AST_TG_ONLY_H1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tg_i |-> !h1_i); // R8

    AST_H1_RISE_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(h1_i) |-> done_i); // R6

    AST_DONE_NEEDS_H1_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> $rose(h1_i)); // R6

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> !done_i); // R6

    AST_PINNED_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && mode_i) |-> !(v1_i || v2_i || v3_i)); // R4

endmodule

bind vxs_seq vxs_seq_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .v1_i  (v1_o),
    .v2_i  (v2_o),
    .v3_i  (v3_o),
    .tg_i  (tg_o),
    .h1_i  (h1_o),
    .done_i(done_o),
    .mode_i(mode_q)
);

// File: tb/vxs_seq_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the vertical row-transfer sequencer.
module vxs_seq_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic mpp_i = 1'b0;
    logic v1_o, v2_o, v3_o, tg_o, h1_o, done_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vxs_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mpp_i(mpp_i),
        .v1_o(v1_o), .v2_o(v2_o), .v3_o(v3_o), .tg_o(tg_o), .h1_o(h1_o),
        .done_o(done_o)
    );

    function automatic logic [4:0] outs();
        return {v1_o, v2_o, v3_o, tg_o, h1_o};
    endfunction

    function automatic int tk(input int ns);
        return (ns * 200 + 999) / 1000;
    endfunction

    // Expected levels {V1,V2,V3,TG,H1} after step k
    function automatic logic [4:0] exp_lvl(input logic mpp, input int k);
        logic [4:0] s [0:8] = '{5'b11010, 5'b01010, 5'b01110, 5'b00110, 5'b10110,
                                5'b10010, 5'b11010, 5'b11000, 5'b11001};
        logic [4:0] p [0:8] = '{5'b00010, 5'b01010, 5'b01110, 5'b00110, 5'b10110,
                                5'b10010, 5'b00000, 5'b00001, 5'b00001};
        return mpp ? p[k] : s[k];
    endfunction

    // Expected gap in ns before step k (k >= 1)
    function automatic int exp_gap_ns(input logic mpp, input int k);
        int s [0:8] = '{0, 2600, 2600, 2600, 5200, 1400, 1400, 4600, 2600};
        int p [0:8] = '{0, 2600, 5200, 2600, 2600, 2800, 4600, 2600, 0};
        return mpp ? p[k] : s[k];
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reset levels follow mpp_i in both modes (R1)
    task automatic t_reset();
        rst_n = 1'b0;
        mpp_i = 1'b1;
        repeat (2) @(negedge clk);
        chk(outs() == 5'b00001, "R1 reset pinned idle", outs(), 5'b00001);
        chk(done_o == 1'b0, "R6 no done in reset", done_o, 0);
        mpp_i = 1'b0;
        @(negedge clk);
        chk(outs() == 5'b11001, "R1 reset standard idle", outs(), 5'b11001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(outs() == 5'b11001, "R1 idle after reset", outs(), 5'b11001);
    endtask

    // Idle vertical levels switch with mode, one edge later, H1 held (R1)
    task automatic t_idle_switch();
        @(negedge clk);
        mpp_i = 1'b1;
        @(negedge clk);
        chk(outs() == 5'b00001, "R1 idle switch to pinned", outs(), 5'b00001);
        mpp_i = 1'b0;
        @(negedge clk);
        chk(outs() == 5'b11001, "R1 idle switch to standard", outs(), 5'b11001);
    endtask

    // Full run checking each edge position; optional disturbance (R2..R7)
    task automatic t_run(input logic mpp, input bit disturb);
        int last_k;
        string rq;
        last_k = mpp ? 7 : 8;
        rq = mpp ? "R4" : "R3";
        @(negedge clk);
        mpp_i = mpp;
        repeat (3) @(negedge clk);
        chk(outs() == exp_lvl(mpp, last_k), "R1 idle before start", outs(), exp_lvl(mpp, last_k));
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(outs() == exp_lvl(mpp, 0), "R2 start step", outs(), exp_lvl(mpp, 0));
        for (int k = 1; k <= last_k; k++) begin
            int g;
            logic [4:0] prev;
            prev = exp_lvl(mpp, k - 1);
            g = tk(exp_gap_ns(mpp, k));
            for (int c = 1; c < g; c++) begin
                @(negedge clk);
                start_i = disturb && (k == 2);
                mpp_i = (disturb && (k == 2 || k == 3)) ? ~mpp : mpp;
            end
            chk(outs() == prev, disturb ? "R7 held before edge" : {rq, " R5 held before edge"},
                outs(), prev);
            @(negedge clk);
            start_i = 1'b0;
            mpp_i = mpp;
            chk(outs() == exp_lvl(mpp, k), disturb ? "R7 edge level" : {rq, " R5 edge level"},
                outs(), exp_lvl(mpp, k));
            chk(done_o == (k == last_k), "R6 done at H1 rise", done_o, (k == last_k));
        end
        @(negedge clk);
        chk(done_o == 1'b0, "R6 done one cycle", done_o, 0);
        chk(outs() == exp_lvl(mpp, last_k), "R1 idle after run", outs(), exp_lvl(mpp, last_k));
    endtask

    initial begin
        t_reset();
        t_idle_switch();
        t_run(1'b0, 1'b0);
        t_run(1'b1, 1'b0);
        t_run(1'b0, 1'b1);
        t_run(1'b1, 1'b1);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check
    initial begin
        #600000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule